// File: doc/BRIEF.md
# Lock Region Protection Unit

This unit keeps the write and erase protection state of a nonvolatile array that is carved into equal lock regions of 8 Mb each. With 16-bit words, the region holding a word is found by dropping the low 19 bits of its word address. Each region sits at one of three protection levels: open, shut or sealed. A command port changes the level of one region at a time. A request port takes a word address for a program or erase and answers one cycle later with a grant or a refusal.

A supply-level input reports that the program voltage is too low. While it is high, every request is refused, whatever the level of the region. The same input is watched around embedded operations. An operation must not begin unless the supply level has been steady for a guard window of clock cycles. The level must also stay unchanged until the operation ends. A breach of either rule raises a sticky violation flag. Refusals raise a sticky protection-error flag. A clear command clears both flags.

Top module: `lockreg_unit`

## Requirements
- R1: A request for word address A is judged against region A >> 19. The region index is the upper ADDR_W-19 address bits. The offset within the region has no effect.
- R2: After reset every region is shut, both sticky flags are low, and every request is refused.
- R3: Command code 2'b01 opens one region and code 2'b00 shuts one region. No other region changes. A request to an open region is granted, and a request to a shut region is refused.
- R4: Command code 2'b10 seals a region. A sealed region refuses requests. Open (2'b01) and shut (2'b00) commands to it are ignored until the next reset, and reset returns it to shut.
- R5: While vpp_low is high, every request is refused, including requests to open regions.
- R6: Exactly one of rsp_grant and rsp_deny is high in the cycle after a request is accepted. Both are low in the cycle after a cycle with no request.
- R7: A refusal sets prot_err, which then holds. Command code 2'b11 clears it. A refusal in the same cycle as a clear leaves the flag set.
- R8: A region command whose index is REGIONS or above has no effect. A request whose address falls at or above region REGIONS is refused.
- R9: When a command and a request arrive in the same cycle, the request is judged on the region level before the command takes effect.
- R10: When op_busy rises, vpp_viol is set if vpp_low changed at that edge. It is also set if vpp_low changed within the GUARD_CYCLES edges before that edge. The change history starts empty at reset, so an operation begun too soon after reset is flagged.
- R11: A change of vpp_low while op_busy is high sets vpp_viol. A change while op_busy is low sets nothing.
- R12: vpp_viol holds until command code 2'b11, and a new violation in the clearing cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 shut, 01 open, 10 seal, 11 clear flags |
| cmd_region | input | ADDR_W-19 | Region index for the command |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | ADDR_W | Word address of the request |
| vpp_low | input | 1 | Program voltage below the safe level |
| op_busy | input | 1 | Embedded operation in progress |
| rsp_grant | output | 1 | Request granted (one cycle after the request) |
| rsp_deny | output | 1 | Request refused (one cycle after the request) |
| prot_err | output | 1 | Sticky protection-error flag |
| vpp_viol | output | 1 | Sticky supply-stability violation flag |

## Verification
Two pairs of functions can act in the same clock cycle. The first pair is a clear command and a refusal that sets the error flag. The second pair is a region command and a request aimed at the same region. The bench drives each pair on one edge. It judges the result from the rule that a new error outranks a clear, and from the rule that a request sees the region level from before the edge. A sealed region given a later open command is probed through a request after that command. An operation is started a few cycles after a supply change, and again well past the guard window, to show both sides of the window.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;

  typedef enum logic [1:0] {
    PL_OPEN   = 2'd0,
    PL_SHUT   = 2'd1,
    PL_SEALED = 2'd2
  } prot_lvl_e;

  typedef enum logic [1:0] {
    OP_SHUT  = 2'd0,
    OP_OPEN  = 2'd1,
    OP_SEAL  = 2'd2,
    OP_CLEAR = 2'd3
  } cmd_op_e;

  // Level a region moves to when a command addresses it.
  function automatic prot_lvl_e next_level(prot_lvl_e cur, cmd_op_e op);
    prot_lvl_e nxt;
    nxt = cur;
    case (op)
      OP_SHUT:  if (cur != PL_SEALED) nxt = PL_SHUT;
      OP_OPEN:  if (cur != PL_SEALED) nxt = PL_OPEN;
      OP_SEAL:  nxt = PL_SEALED;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

  // A request passes only for an in-range open region with a healthy supply.
  function automatic logic may_write(logic in_range, logic region_open, logic low_supply);
    return in_range && region_open && !low_supply;
  endfunction

endpackage

// File: rtl/lockreg_table.sv
module lockreg_table
  import lockreg_pkg::*;
#(
  parameter int REGIONS = 96,
  parameter int IDX_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  cmd_op_e          cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_in_range,
  output logic             look_open,
  output logic             cmd_in_range
);
  localparam int SLOTS = 2 ** IDX_W;

  prot_lvl_e          lvl [REGIONS];
  logic [SLOTS-1:0]   open_pad;

  assign cmd_in_range  = (32'(cmd_idx) < REGIONS);
  assign look_in_range = (32'(look_idx) < REGIONS);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < REGIONS) begin : g_real
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lvl[g] <= PL_SHUT;
        end else if (cmd_valid && cmd_idx == IDX_W'(g)) begin
          lvl[g] <= next_level(lvl[g], cmd_op);
        end
      end
      assign open_pad[g] = (lvl[g] == PL_OPEN);
    end else begin : g_pad
      assign open_pad[g] = 1'b0;
    end
  end

  assign look_open = look_in_range && open_pad[look_idx];

endmodule

// File: rtl/lockreg_gate.sv
module lockreg_gate
  import lockreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic in_range,
  input  logic region_open,
  input  logic vpp_low,
  input  logic clr_now,
  output logic pass_now,
  output logic deny_now,
  output logic rsp_grant,
  output logic rsp_deny,
  output logic prot_err
);
  assign pass_now = req_valid && may_write(in_range, region_open, vpp_low);
  assign deny_now = req_valid && !pass_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_grant <= 1'b0;
      rsp_deny  <= 1'b0;
      prot_err  <= 1'b0;
    end else begin
      rsp_grant <= pass_now;
      rsp_deny  <= deny_now;
      if (deny_now)     prot_err <= 1'b1;
      else if (clr_now) prot_err <= 1'b0;
    end
  end

endmodule

// File: rtl/lockreg_vpp.sv
module lockreg_vpp #(
  parameter int GUARD_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vpp_low,
  input  logic op_busy,
  input  logic clr_now,
  output logic vpp_change,
  output logic op_start,
  output logic viol_set,
  output logic vpp_viol
);
  localparam int CW = $clog2(GUARD_CYCLES + 1);

  logic          vpp_q;
  logic          busy_q;
  logic [CW-1:0] calm;
  logic          early_start;

  assign vpp_change  = vpp_low ^ vpp_q;
  assign op_start    = op_busy && !busy_q;
  assign early_start = op_start && (vpp_change || calm < CW'(GUARD_CYCLES));
  assign viol_set    = early_start || (op_busy && vpp_change);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpp_q    <= 1'b0;
      busy_q   <= 1'b0;
      calm     <= '0;
      vpp_viol <= 1'b0;
    end else begin
      vpp_q  <= vpp_low;
      busy_q <= op_busy;
      if (vpp_change)                     calm <= '0;
      else if (calm < CW'(GUARD_CYCLES))  calm <= calm + 1'b1;
      if (viol_set)     vpp_viol <= 1'b1;
      else if (clr_now) vpp_viol <= 1'b0;
    end
  end

endmodule

// File: rtl/lockreg_unit.sv
module lockreg_unit
  import lockreg_pkg::*;
#(
  parameter int ADDR_W       = 26,
  parameter int REGION_SHIFT = 19,
  parameter int REGIONS      = 96,
  parameter int GUARD_CYCLES = 250,
  localparam int IDX_W       = ADDR_W - REGION_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_region,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              vpp_low,
  input  logic              op_busy,
  output logic              rsp_grant,
  output logic              rsp_deny,
  output logic              prot_err,
  output logic              vpp_viol
);
  function automatic logic [IDX_W-1:0] region_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:REGION_SHIFT];
  endfunction

  cmd_op_e          op_e;
  logic [IDX_W-1:0] req_idx;
  logic             clr_now;
  logic             look_in_range;
  logic             look_open;
  logic             cmd_in_range;
  logic             pass_now;
  logic             deny_now;
  logic             vpp_change;
  logic             op_start;
  logic             viol_set;

  assign op_e    = cmd_op_e'(cmd_op);
  assign req_idx = region_of(req_addr);
  assign clr_now = cmd_valid && (op_e == OP_CLEAR);

  lockreg_table #(.REGIONS(REGIONS), .IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_e),
    .cmd_idx(cmd_region), .look_idx(req_idx), .look_in_range(look_in_range),
    .look_open(look_open), .cmd_in_range(cmd_in_range)
  );

  lockreg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .in_range(look_in_range),
    .region_open(look_open), .vpp_low(vpp_low), .clr_now(clr_now),
    .pass_now(pass_now), .deny_now(deny_now), .rsp_grant(rsp_grant),
    .rsp_deny(rsp_deny), .prot_err(prot_err)
  );

  lockreg_vpp #(.GUARD_CYCLES(GUARD_CYCLES)) u_vpp (
    .clk(clk), .rst_n(rst_n), .vpp_low(vpp_low), .op_busy(op_busy),
    .clr_now(clr_now), .vpp_change(vpp_change), .op_start(op_start),
    .viol_set(viol_set), .vpp_viol(vpp_viol)
  );

endmodule

// File: rtl/lockreg_unit_chk.sv
module lockreg_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic vpp_low,
  input logic op_busy,
  input logic clr_now,
  input logic vpp_change,
  input logic rsp_grant,
  input logic rsp_deny,
  input logic prot_err,
  input logic vpp_viol
);
  a_r5_low_supply_denies: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && vpp_low |=> rsp_deny && !rsp_grant);

  a_r6_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_grant ^ rsp_deny));

  a_r6_no_idle_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_grant && !rsp_deny);

  a_r7_deny_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny |-> prot_err);

  a_r7_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err && !clr_now |=> prot_err);

  a_r11_change_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy && vpp_change |=> vpp_viol);

  a_r12_viol_holds: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_viol && !clr_now |=> vpp_viol);
endmodule

bind lockreg_unit lockreg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vpp_low(vpp_low),
  .op_busy(op_busy), .clr_now(clr_now), .vpp_change(vpp_change),
  .rsp_grant(rsp_grant), .rsp_deny(rsp_deny), .prot_err(prot_err),
  .vpp_viol(vpp_viol)
);

// File: tb/sim_lockreg_unit.sv
`timescale 1ns/1ps
module sim_lockreg_unit;
  localparam int AW = 26;
  localparam int SH = 19;
  localparam int IW = AW - SH;
  localparam int GUARD = 250;

  typedef struct packed {
    logic          is_req;
    logic [1:0]    op;
    logic [IW-1:0] rg;
    logic          vlow;
    logic          exp_ok;
    logic [3:0]    rq;
  } vec_t;

  // rq holds the requirement number each row exercises
  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 7'd0,   1'b0, 1'b0, 4'd2},  // R2 all shut
    '{1'b1, 2'd0, 7'd95,  1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 2'd1, 7'd3,   1'b0, 1'b0, 4'd3},  // open r3
    '{1'b1, 2'd0, 7'd3,   1'b0, 1'b1, 4'd3},  // R3
    '{1'b1, 2'd0, 7'd4,   1'b0, 1'b0, 4'd3},  // R3 neighbour
    '{1'b1, 2'd0, 7'd2,   1'b0, 1'b0, 4'd3},  // R3 neighbour
    '{1'b0, 2'd1, 7'd4,   1'b0, 1'b0, 4'd3},
    '{1'b1, 2'd0, 7'd4,   1'b0, 1'b1, 4'd3},  // R3
    '{1'b0, 2'd0, 7'd3,   1'b0, 1'b0, 4'd3},  // shut r3
    '{1'b1, 2'd0, 7'd3,   1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 2'd0, 7'd4,   1'b0, 1'b1, 4'd3},  // R3
    '{1'b1, 2'd0, 7'd4,   1'b1, 1'b0, 4'd5},  // R5 low supply
    '{1'b1, 2'd0, 7'd4,   1'b0, 1'b1, 4'd5},  // R5 recovers
    '{1'b0, 2'd2, 7'd4,   1'b0, 1'b0, 4'd4},  // seal r4
    '{1'b1, 2'd0, 7'd4,   1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd1, 7'd4,   1'b0, 1'b0, 4'd4},  // open ignored
    '{1'b1, 2'd0, 7'd4,   1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd0, 7'd4,   1'b0, 1'b0, 4'd4},
    '{1'b0, 2'd1, 7'd4,   1'b0, 1'b0, 4'd4},
    '{1'b1, 2'd0, 7'd4,   1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd1, 7'd100, 1'b0, 1'b0, 4'd8},  // out of range open
    '{1'b1, 2'd0, 7'd100, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 2'd1, 7'd95,  1'b0, 1'b0, 4'd1},
    '{1'b1, 2'd0, 7'd95,  1'b0, 1'b1, 4'd1}   // R1 last region
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [IW-1:0] cmd_region = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          vpp_low = 1'b0;
  logic          op_busy = 1'b0;
  logic          rsp_grant, rsp_deny, prot_err, vpp_viol;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  lockreg_unit #(.ADDR_W(AW), .REGION_SHIFT(SH), .REGIONS(96), .GUARD_CYCLES(GUARD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_region(cmd_region), .req_valid(req_valid), .req_addr(req_addr),
    .vpp_low(vpp_low), .op_busy(op_busy), .rsp_grant(rsp_grant),
    .rsp_deny(rsp_deny), .prot_err(prot_err), .vpp_viol(vpp_viol)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_in(logic [IW-1:0] rg, logic [SH-1:0] off);
    return {rg, off};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_cmd(logic [1:0] op, logic [IW-1:0] rg);
    cmd_valid = 1'b1; cmd_op = op; cmd_region = rg;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  task automatic send_req(logic [AW-1:0] a, logic v);
    req_valid = 1'b1; req_addr = a; vpp_low = v;
    tick(1);
    req_valid = 1'b0; vpp_low = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R2 reset prot_err", 32'(prot_err), 0);
    check("R2 reset vpp_viol", 32'(vpp_viol), 0);
    check("R6 idle grant", 32'(rsp_grant), 0);
    check("R6 idle deny", 32'(rsp_deny), 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_req) begin
        send_req(addr_in(VECS[i].rg, 19'(32'h1a5 * (i + 1))), VECS[i].vlow);
        check($sformatf("R%0d vec%0d grant", VECS[i].rq, i), 32'(rsp_grant), 32'(VECS[i].exp_ok));
        check($sformatf("R%0d vec%0d deny", VECS[i].rq, i), 32'(rsp_deny), 32'(!VECS[i].exp_ok));
      end else begin
        send_cmd(VECS[i].op, VECS[i].rg);
      end
    end

    // R1: offset extremes inside one open region
    send_req(addr_in(7'd95, '1), 1'b0);
    check("R1 top offset grant", 32'(rsp_grant), 1);
    send_req(addr_in(7'd95, '0), 1'b0);
    check("R1 zero offset grant", 32'(rsp_grant), 1);
    tick(1);
    check("R6 no answer without request", 32'(rsp_grant | rsp_deny), 0);

    // R7: sticky error, clear, and clear racing a refusal
    check("R7 error set earlier", 32'(prot_err), 1);
    send_cmd(2'd3, 7'd0);
    check("R7 cleared", 32'(prot_err), 0);
    cmd_valid = 1'b1; cmd_op = 2'd3; req_valid = 1'b1; req_addr = addr_in(7'd20, 19'h10);
    tick(1);
    cmd_valid = 1'b0; req_valid = 1'b0;
    check("R7 refusal beats clear", 32'(prot_err), 1);
    send_cmd(2'd3, 7'd0);

    // R9: open and request same region on one edge
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_region = 7'd10;
    req_valid = 1'b1; req_addr = addr_in(7'd10, 19'h7);
    tick(1);
    cmd_valid = 1'b0; req_valid = 1'b0;
    check("R9 judged on old level", 32'(rsp_deny), 1);
    send_req(addr_in(7'd10, 19'h7), 1'b0);
    check("R9 open afterwards", 32'(rsp_grant), 1);
    send_cmd(2'd3, 7'd0);

    // R10: start shortly after a supply change
    tick(GUARD + 20);
    vpp_low = 1'b1;
    tick(6);
    op_busy = 1'b1;
    tick(1);
    check("R10 early start flagged", 32'(vpp_viol), 1);
    op_busy = 1'b0;
    tick(2);
    vpp_low = 1'b0;
    tick(3);
    check("R12 viol held", 32'(vpp_viol), 1);
    send_cmd(2'd3, 7'd0);
    check("R12 viol cleared", 32'(vpp_viol), 0);
    tick(GUARD + 20);
    op_busy = 1'b1;
    tick(4);
    check("R10 late start clean", 32'(vpp_viol), 0);
    vpp_low = 1'b1;
    tick(1);
    check("R11 change in op flagged", 32'(vpp_viol), 1);
    vpp_low = 1'b0;
    tick(1);
    op_busy = 1'b0;
    tick(1);
    send_cmd(2'd3, 7'd0);
    vpp_low = 1'b1;
    tick(2);
    vpp_low = 1'b0;
    tick(2);
    check("R11 change when idle clean", 32'(vpp_viol), 0);

    // R4: reset unseals region 4 back to shut
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    send_req(addr_in(7'd4, 19'h3), 1'b0);
    check("R2 region shut after reset", 32'(rsp_deny), 1);
    send_cmd(2'd1, 7'd4);
    send_req(addr_in(7'd4, 19'h3), 1'b0);
    check("R4 reset lifts seal", 32'(rsp_grant), 1);

    finish_run();
  end
endmodule